// File: doc/BRIEF.md
# Bit-Test Conditional Skip Unit

This block sits beside the execute stage of a two-stage fetch/execute pipeline. When the instruction in execute is a bit-test instruction, the block looks at one chosen bit of the 8-bit file-register value that was read for it. It then decides whether the instruction that follows must be thrown away. The follower is not removed from the stream. It is still fetched, then runs through execute as a NOP. A taken test therefore costs one extra instruction cycle.

The decision is held in a single pending-squash register. That register marks exactly the next instruction that advances into execute, then clears itself. An instruction that is squashed has no effect at all. A bit-test instruction sitting in a squashed slot therefore cannot start a skip of its own.

The block drives the register-file read address for the test operand. It never touches any status flag.

Top module: `bit_skip_unit`

## Requirements
- R1: A synchronous active-high `rst` clears any pending squash, so `nop_o` reads 0 in the cycle after a clock edge with `rst` high.
- R2: With `op_class_i` = 2'b01 (skip-if-set), `adv_i` = 1, `nop_o` = 0, and `rd_data_i[bit_idx_i]` = 1, `take_o` is 1 in that cycle and `nop_o` is 1 after the next clock edge.
- R3: With `op_class_i` = 2'b01 and the selected bit 0, `take_o` stays 0 and `nop_o` stays 0.
- R4: With `op_class_i` = 2'b10 (skip-if-clear), `adv_i` = 1, `nop_o` = 0, and the selected bit 0, `take_o` is 1 and `nop_o` is 1 after the next clock edge.
- R5: With `op_class_i` = 2'b10 and the selected bit 1, `take_o` stays 0 and `nop_o` stays 0.
- R6: `bit_idx_i` value i selects `rd_data_i[i]`, with bit 0 the least significant, for every index 0 to 7.
- R7: Once set, `nop_o` stays 1 through cycles with `adv_i` = 0. It returns to 0 after the first clock edge at which `adv_i` = 1.
- R8: While `nop_o` = 1, `take_o` is 0 whatever the instruction and data, so a squashed bit-test cannot cause a skip.
- R9: The `op_class_i` codes 2'b00 and 2'b11 (non-test instructions) never raise `take_o`.
- R10: `rd_addr_o` equals `reg_addr_i` (7-bit address, 0 to 127) in every cycle.
- R11: With `adv_i` = 0, no test is evaluated. `take_o` is 0, and a clear `nop_o` stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Instruction in execute advances this cycle |
| op_class_i | input | 2 | Opcode class: 01 skip-if-set, 10 skip-if-clear, 00/11 other |
| reg_addr_i | input | 7 | File-register address of the test operand |
| bit_idx_i | input | 3 | Index of the bit to test |
| rd_data_i | input | 8 | Register read data for the test operand |
| rd_addr_o | output | 7 | Read address presented to the register file |
| take_o | output | 1 | Test in execute takes the skip; an extra cycle follows |
| nop_o | output | 1 | Instruction in execute is squashed and runs as a NOP |

## Verification
The hardest case to reach is a bit-test instruction arriving in a slot that is already squashed while its own condition holds. If this case were handled wrongly, the squashed instruction would start a second skip. The stimulus gets there by first taking a skip, then presenting a true-condition test on the very next advance and checking that `take_o` stays low and `nop_o` clears. Stalls with `adv_i` low are inserted both while a squash is pending and while a true test is presented without advancing. Reset is applied in the middle of a pending squash.

// File: rtl/bskip_pkg.sv
package bskip_pkg;
   typedef enum logic [1:0] {
      OPC_OTHER    = 2'b00,
      OPC_SKIP_SET = 2'b01,
      OPC_SKIP_CLR = 2'b10,
      OPC_RSVD     = 2'b11
   } op_class_e;
endpackage

// File: rtl/bskip_bitsel.sv
module bskip_bitsel #(
   parameter int DATA_W     = 8,
   parameter int IDX_W      = 3,
   parameter bit SEL_ONEHOT = 1'b0
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic              bit_o
);
   generate
      if (SEL_ONEHOT) begin : g_mask
         logic [DATA_W-1:0] mask;
         always_comb begin
            mask = '0;
            mask[idx_i] = 1'b1;
            bit_o = |(data_i & mask);
         end
      end else begin : g_mux
         always_comb bit_o = data_i[idx_i];
      end
   endgenerate
endmodule

// File: rtl/bskip_cond.sv
module bskip_cond
   import bskip_pkg::*;
(
   input  logic [1:0] op_i,
   input  logic       bit_i,
   input  logic       adv_i,
   input  logic       squashed_i,
   output logic       take_o
);
   op_class_e op;
   logic      hit;

   always_comb begin
      op = op_class_e'(op_i);
      unique case (op)
         OPC_SKIP_SET: hit = bit_i;
         OPC_SKIP_CLR: hit = ~bit_i;
         default:      hit = 1'b0;
      endcase
      take_o = adv_i & ~squashed_i & hit;
   end
endmodule

// File: rtl/bskip_squash.sv
module bskip_squash (
   input  logic clk,
   input  logic rst,
   input  logic adv_i,
   input  logic take_i,
   output logic pend_o
);
   always_ff @(posedge clk) begin
      if (rst)         pend_o <= 1'b0;
      else if (take_i) pend_o <= 1'b1;
      else if (adv_i)  pend_o <= 1'b0;
   end
endmodule

// File: rtl/bit_skip_unit.sv
module bit_skip_unit #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 7,
   parameter bit SEL_ONEHOT = 1'b0,
   localparam int IDX_W     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_i,
   input  logic [1:0]        op_class_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [IDX_W-1:0]  bit_idx_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              take_o,
   output logic              nop_o
);
   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("bit_skip_unit: DATA_W must be a power of two of at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("bit_skip_unit: ADDR_W must be at least 1");
      end
   endgenerate

   logic sel_bit;

   assign rd_addr_o = reg_addr_i;

   bskip_bitsel #(
      .DATA_W    (DATA_W),
      .IDX_W     (IDX_W),
      .SEL_ONEHOT(SEL_ONEHOT)
   ) u_sel (
      .data_i(rd_data_i),
      .idx_i (bit_idx_i),
      .bit_o (sel_bit)
   );

   bskip_cond u_cond (
      .op_i      (op_class_i),
      .bit_i     (sel_bit),
      .adv_i     (adv_i),
      .squashed_i(nop_o),
      .take_o    (take_o)
   );

   bskip_squash u_sq (
      .clk   (clk),
      .rst   (rst),
      .adv_i (adv_i),
      .take_i(take_o),
      .pend_o(nop_o)
   );
endmodule

// File: rtl/bskip_chk.sv
module bskip_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst,
   input logic              adv_i,
   input logic [1:0]        op_class_i,
   input logic [IDX_W-1:0]  bit_idx_i,
   input logic [DATA_W-1:0] rd_data_i,
   input logic              take_o,
   input logic              nop_o
);
   p_take_marks_next_r2: assert property (@(posedge clk) disable iff (rst)
      take_o |=> nop_o);

   p_set_hit_r2: assert property (@(posedge clk) disable iff (rst)
      (adv_i && !nop_o && op_class_i == 2'b01 && rd_data_i[bit_idx_i]) |-> take_o);

   p_clr_hit_r4: assert property (@(posedge clk) disable iff (rst)
      (adv_i && !nop_o && op_class_i == 2'b10 && !rd_data_i[bit_idx_i]) |-> take_o);

   p_nop_holds_r7: assert property (@(posedge clk) disable iff (rst)
      (nop_o && !adv_i) |=> nop_o);

   p_nop_clears_r7: assert property (@(posedge clk) disable iff (rst)
      (nop_o && adv_i) |=> !nop_o);

   p_squashed_inert_r8: assert property (@(posedge clk) disable iff (rst)
      nop_o |-> !take_o);

   p_other_inert_r9: assert property (@(posedge clk) disable iff (rst)
      (op_class_i == 2'b00 || op_class_i == 2'b11) |-> !take_o);

   p_stall_inert_r11: assert property (@(posedge clk) disable iff (rst)
      !adv_i |-> !take_o);

   p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
      (!nop_o && !take_o) |=> !nop_o);
endmodule

bind bit_skip_unit bskip_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .adv_i     (adv_i),
   .op_class_i(op_class_i),
   .bit_idx_i (bit_idx_i),
   .rd_data_i (rd_data_i),
   .take_o    (take_o),
   .nop_o     (nop_o)
);

// File: tb/bit_skip_unit_bench.sv
`timescale 1ns/1ps
module bit_skip_unit_bench;
   logic       clk = 1'b0;
   logic       rst;
   logic       adv_i;
   logic [1:0] op_class_i;
   logic [6:0] reg_addr_i;
   logic [2:0] bit_idx_i;
   logic [7:0] rd_data_i;
   logic [6:0] rd_addr_o;
   logic       take_o;
   logic       nop_o;

   int nchecks = 0;
   int nfail   = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   bit_skip_unit u_bit_skip_unit (
      .clk       (clk),
      .rst       (rst),
      .adv_i     (adv_i),
      .op_class_i(op_class_i),
      .reg_addr_i(reg_addr_i),
      .bit_idx_i (bit_idx_i),
      .rd_data_i (rd_data_i),
      .rd_addr_o (rd_addr_o),
      .take_o    (take_o),
      .nop_o     (nop_o)
   );

   // {op[1:0], idx[2:0], data[7:0], expected take}; idx walks bits for R6
   localparam logic [13:0] VEC [0:11] = '{
      {2'b01, 3'd0, 8'h01, 1'b1},
      {2'b01, 3'd0, 8'hFE, 1'b0},
      {2'b01, 3'd7, 8'h80, 1'b1},
      {2'b01, 3'd7, 8'h7F, 1'b0},
      {2'b10, 3'd3, 8'hF7, 1'b1},
      {2'b10, 3'd3, 8'h08, 1'b0},
      {2'b10, 3'd5, 8'h00, 1'b1},
      {2'b10, 3'd5, 8'hFF, 1'b0},
      {2'b00, 3'd2, 8'h04, 1'b0},
      {2'b11, 3'd2, 8'h04, 1'b0},
      {2'b01, 3'd4, 8'h10, 1'b1},
      {2'b10, 3'd1, 8'hFD, 1'b1}
   };

   function automatic string tag(input logic [1:0] op, input logic ex);
      if (op == 2'b01) return ex ? "R2/R6" : "R3/R6";
      if (op == 2'b10) return ex ? "R4/R6" : "R5/R6";
      return "R9";
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchecks++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic a, input logic [1:0] op, input logic [2:0] idx,
                        input logic [7:0] d);
      @(negedge clk);
      adv_i = a; op_class_i = op; bit_idx_i = idx; rd_data_i = d;
      #1;
   endtask

   task automatic edge_settle();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         nfail++;
         nchecks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; adv_i = 1'b0; op_class_i = 2'b00; bit_idx_i = '0;
      rd_data_i = '0; reg_addr_i = 7'd0;
      repeat (2) @(posedge clk);
      #1;
      chk("R1", nop_o, 0);
      @(negedge clk) rst = 1'b0;

      // table walk
      for (int i = 0; i < 12; i++) begin
         drive(1'b1, VEC[i][13:12], VEC[i][11:9], VEC[i][8:1]);
         chk(tag(VEC[i][13:12], VEC[i][0]), take_o, VEC[i][0]);
         edge_settle();
         chk(tag(VEC[i][13:12], VEC[i][0]), nop_o, VEC[i][0]);
         drive(1'b1, 2'b00, 3'd0, 8'h00);
         edge_settle();
         chk("R7", nop_o, 0);
      end

      // R11: true test presented without advance
      drive(1'b0, 2'b01, 3'd2, 8'h04);
      chk("R11", take_o, 0);
      edge_settle();
      chk("R11", nop_o, 0);

      // R7: pending squash held across stalls
      drive(1'b1, 2'b10, 3'd6, 8'h00);
      edge_settle();
      drive(1'b0, 2'b00, 3'd0, 8'h00);
      edge_settle();
      drive(1'b0, 2'b00, 3'd0, 8'h00);
      edge_settle();
      chk("R7", nop_o, 1);

      // R8: squashed slot holds a true-condition test
      drive(1'b1, 2'b01, 3'd3, 8'h08);
      chk("R8", take_o, 0);
      edge_settle();
      chk("R8", nop_o, 0);
      // same test, now unsquashed, does skip
      drive(1'b1, 2'b01, 3'd3, 8'h08);
      chk("R2", take_o, 1);
      edge_settle();

      // R1: reset during pending squash
      chk("R1", nop_o, 1);
      @(negedge clk) rst = 1'b1; adv_i = 1'b0;
      edge_settle();
      chk("R1", nop_o, 0);
      @(negedge clk) rst = 1'b0;

      // R10: read address pass-through
      for (int a = 0; a < 128; a += 37) begin
         @(negedge clk) reg_addr_i = 7'(a);
         #1;
         chk("R10", {1'b0, rd_addr_o}, 8'(a));
      end
      @(negedge clk) reg_addr_i = 7'd127;
      #1;
      chk("R10", {1'b0, rd_addr_o}, 8'd127);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end
endmodule